// File: doc/BRIEF.md
# Conversion Group Trigger Controller

This block sequences conversion requests for a converter that is shared by several conversion groups. Each group keeps its own channel number, its own interrupt enable, its own result slot and its own done flag. At any moment at most one group owns the converter. The block starts a conversion with a one-cycle start pulse and a channel number. It then waits for the converter to return a done pulse with a result. It stores that result against the owning group and raises interrupt and DMA request pulses.

There are two trigger modes. In software mode, only a write to group 0 starts a conversion. In hardware mode, a trigger line per group queues that group. Queued groups are served lowest index first, and each group holds at most one pending trigger. A write to the group that owns the converter aborts its conversion. A write to any other group is harmless. With continuous mode on, a completed group re-queues itself. With overwrite off, a new result cannot replace a result that is still flagged. Two sticky error and event flags are cleared by writing ones to them.

Top module: `adc_grp_ctrl`

## Requirements
- R1: A launch drives `conv_start` high for exactly one cycle and, in that cycle, drives `conv_chan` with the 5-bit channel (0 to 31) stored for the launching group. `busy` is high from the next cycle on.
- R2: In software mode (`hw_mode`=0), a write to group 0 causes a launch in the cycle after the write. Writes to groups 1 and above never launch, and `hw_trig` is ignored.
- R3: In hardware mode, `hw_trig[g]` queues group g. When the converter is idle, the lowest-index queued group launches in the next cycle. Writes never launch in this mode.
- R4: A write to the active group while `busy` ends the conversion at that clock edge, and a `conv_done` in the same cycle is discarded. A write to any other group leaves the active conversion running.
- R5: `done_flags[g]` (bit index equals group index) becomes 1 in the cycle after group g's result is stored, and `rd_data` then shows that result while `rd_grp`=g. The flag clears after a cycle with `rd_en` and `rd_grp`=g, or after a write to group g. A store in the same cycle as the read wins over the read.
- R6: In the cycle after a stored result, `irq` pulses for one cycle if that group's interrupt enable is set. In the same cycle, `dma_req` pulses if `dma_en` was high.
- R7: Each group queues at most one pending trigger. Any number of triggers that arrive while the group is busy produce exactly one relaunch.
- R8: With `ovwr_en`=0, a result for a group whose flag is still set is dropped, with no `irq`. With `ovwr_en`=1, the new result replaces the old one.
- R9: With `cont_en`=1, a completing group is queued again and relaunches with the same channel in the cycle after completion. With `cont_en`=0 at completion, it does not relaunch.
- R10: `sticky_flags` bit 0 (calibration failure) and bit 1 (wake event) are set by `cal_fail_set` and `wake_set`. They are cleared by the matching `sticky_clr` bit. A set wins over a clear in the same cycle.
- R11: After reset, `busy`, `done_flags`, `irq`, `dma_req`, `conv_start` and `sticky_flags` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_mode | input | 1 | 1 selects hardware triggers, 0 selects software start |
| cont_en | input | 1 | Continuous conversion enable |
| ovwr_en | input | 1 | Allow a new result to replace a flagged one |
| dma_en | input | 1 | Global DMA request enable |
| wr_en | input | 1 | Group register write strobe |
| wr_grp | input | GW (2) | Group index written |
| wr_chan | input | CH_W (5) | Channel number written |
| wr_ie | input | 1 | Interrupt enable written |
| rd_en | input | 1 | Result read strobe, clears the read group's flag |
| rd_grp | input | GW (2) | Group whose result is shown |
| rd_data | output | RES_W (12) | Stored result of `rd_grp` |
| hw_trig | input | NUM_GRP (4) | Per-group hardware trigger pulses |
| conv_start | output | 1 | Start pulse to the converter |
| conv_chan | output | CH_W (5) | Channel for the start pulse |
| conv_done | input | 1 | Converter finished pulse |
| conv_result | input | RES_W (12) | Converter result |
| busy | output | 1 | A conversion is in progress |
| active_grp | output | GW (2) | Group owning the converter |
| done_flags | output | NUM_GRP (4) | Per-group completion flags |
| irq | output | 1 | Interrupt request pulse |
| dma_req | output | 1 | DMA request pulse |
| cal_fail_set | input | 1 | Sets the calibration-failure flag |
| wake_set | input | 1 | Sets the wake-event flag |
| sticky_clr | input | 2 | Write-one-to-clear for the sticky flags |
| sticky_flags | output | 2 | Sticky flags: bit 0 calibration, bit 1 wake |

## Verification
The channel path is swept over all 32 channel numbers in software mode, with the interrupt and DMA enables alternated, so that a wrong channel, a missing pulse or a stuck enable shows up. Every non-empty set of four simultaneous hardware triggers is applied. The observed launch order separates lowest-first service from any other order, and the final flag word shows that no queued group was lost. Directed sequences then separate abort from a harmless idle-group write, one-deep queueing from counting or dropping, overwrite from drop, and continuous relaunch from a single shot. Same-cycle set and clear is applied to the sticky flags.

// File: rtl/adc_grp_pkg.sv
package adc_grp_pkg;

    localparam int STICKY_W = 2;

    // bit positions inside the sticky flag word
    typedef enum int {
        STK_CAL  = 0,
        STK_WAKE = 1
    } stk_bit_e;

endpackage

// File: rtl/adc_grp_pick.sv
// Lowest-index-first selector over a request vector.
module adc_grp_pick #(
    parameter int N = 4,
    parameter int W = 2
) (
    input  logic [N-1:0] req,
    output logic         vld,
    output logic [W-1:0] idx
);

    logic [N:0]   below;
    logic [N-1:0] first;

    assign below[0] = 1'b0;

    for (genvar i = 0; i < N; i++) begin : g_chain
        assign first[i]     = req[i] & ~below[i];
        assign below[i + 1] = below[i] | req[i];
    end

    assign vld = below[N];

    always_comb begin
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (first[i]) idx = idx | W'(i);
        end
    end

endmodule

// File: rtl/adc_grp_sticky.sv
// Set-dominant, write-one-to-clear flag word.
module adc_grp_sticky #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] flags_o
);

    logic [W-1:0] flags_d, flags_q;

    always_comb begin
        flags_d = (flags_q & ~clr_i) | set_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end

    assign flags_o = flags_q;

endmodule

// File: rtl/adc_grp_ctrl.sv
module adc_grp_ctrl #(
    parameter  int NUM_GRP = 4,
    parameter  int CH_W    = 5,
    parameter  int RES_W   = 12,
    localparam int GW      = (NUM_GRP > 1) ? $clog2(NUM_GRP) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               hw_mode,
    input  logic               cont_en,
    input  logic               ovwr_en,
    input  logic               dma_en,
    input  logic               wr_en,
    input  logic [GW-1:0]      wr_grp,
    input  logic [CH_W-1:0]    wr_chan,
    input  logic               wr_ie,
    input  logic               rd_en,
    input  logic [GW-1:0]      rd_grp,
    output logic [RES_W-1:0]   rd_data,
    input  logic [NUM_GRP-1:0] hw_trig,
    output logic               conv_start,
    output logic [CH_W-1:0]    conv_chan,
    input  logic               conv_done,
    input  logic [RES_W-1:0]   conv_result,
    output logic               busy,
    output logic [GW-1:0]      active_grp,
    output logic [NUM_GRP-1:0] done_flags,
    output logic               irq,
    output logic               dma_req,
    input  logic               cal_fail_set,
    input  logic               wake_set,
    input  logic [1:0]         sticky_clr,
    output logic [1:0]         sticky_flags
);

    import adc_grp_pkg::*;

    localparam logic [NUM_GRP-1:0] GRP0_ONLY = NUM_GRP'(1);

    typedef struct packed {
        logic                           busy;
        logic [GW-1:0]                  act;
        logic [NUM_GRP-1:0]             pend;
        logic [NUM_GRP-1:0]             flag;
        logic [NUM_GRP-1:0]             ie;
        logic [NUM_GRP-1:0][CH_W-1:0]   chan;
        logic [NUM_GRP-1:0][RES_W-1:0]  res;
        logic                           irq;
        logic                           dma;
    } st_t;

    st_t s_d, s_q;

    logic [NUM_GRP-1:0] launch_mask;
    logic               pick_vld;
    logic [GW-1:0]      pick_idx;
    logic               wr_ok;
    logic               wr_hit_act;
    logic               fin;
    logic [STICKY_W-1:0] stk_set;

    // software mode only ever launches group 0
    assign launch_mask = hw_mode ? s_q.pend : (s_q.pend & GRP0_ONLY);

    adc_grp_pick #(.N(NUM_GRP), .W(GW)) pick_i (
        .req (launch_mask),
        .vld (pick_vld),
        .idx (pick_idx)
    );

    assign wr_ok      = wr_en && (int'(wr_grp) < NUM_GRP);
    assign wr_hit_act = wr_ok && s_q.busy && (wr_grp == s_q.act);
    assign fin        = s_q.busy && conv_done && !wr_hit_act;

    assign conv_start = !s_q.busy && pick_vld;
    assign conv_chan  = s_q.chan[pick_idx];

    always_comb begin
        s_d     = s_q;
        s_d.irq = 1'b0;
        s_d.dma = 1'b0;

        // stale hardware requests are dropped in software mode
        if (!hw_mode) s_d.pend = s_d.pend & GRP0_ONLY;

        if (conv_start) begin
            s_d.busy           = 1'b1;
            s_d.act            = pick_idx;
            s_d.pend[pick_idx] = 1'b0;
        end

        // triggers arriving now form the next one-deep queue entry
        if (hw_mode) s_d.pend = s_d.pend | hw_trig;

        // read clear comes before a store so a new result wins
        if (rd_en && (int'(rd_grp) < NUM_GRP)) s_d.flag[rd_grp] = 1'b0;

        if (fin) begin
            s_d.busy = 1'b0;
            if (!s_q.flag[s_q.act] || ovwr_en) begin
                s_d.res[s_q.act]  = conv_result;
                s_d.flag[s_q.act] = 1'b1;
                s_d.irq           = s_q.ie[s_q.act];
                s_d.dma           = dma_en;
            end
            if (cont_en) s_d.pend[s_q.act] = 1'b1;
        end

        if (wr_ok) begin
            s_d.chan[wr_grp] = wr_chan;
            s_d.ie[wr_grp]   = wr_ie;
            s_d.flag[wr_grp] = 1'b0;
            if (wr_hit_act) s_d.busy = 1'b0;
            if (!hw_mode && (wr_grp == '0)) s_d.pend[0] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        stk_set           = '0;
        stk_set[STK_CAL]  = cal_fail_set;
        stk_set[STK_WAKE] = wake_set;
    end

    adc_grp_sticky #(.W(STICKY_W)) sticky_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (stk_set),
        .clr_i   (sticky_clr),
        .flags_o (sticky_flags)
    );

    assign rd_data    = s_q.res[rd_grp];
    assign busy       = s_q.busy;
    assign active_grp = s_q.act;
    assign done_flags = s_q.flag;
    assign irq        = s_q.irq;
    assign dma_req    = s_q.dma;

endmodule

// File: rtl/adc_grp_ctrl_chk.sv
module adc_grp_ctrl_chk #(
    parameter int NUM_GRP = 4,
    parameter int GW      = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               hw_mode,
    input logic               dma_en,
    input logic               wr_en,
    input logic [GW-1:0]      wr_grp,
    input logic               rd_en,
    input logic [GW-1:0]      rd_grp,
    input logic               conv_start,
    input logic               conv_done,
    input logic               busy,
    input logic [GW-1:0]      active_grp,
    input logic [NUM_GRP-1:0] done_flags,
    input logic               irq,
    input logic               dma_req,
    input logic               cal_fail_set,
    input logic [1:0]         sticky_flags
);

    AST_START_TAKES_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> busy); // R1

    AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start); // R1

    AST_SW_GROUP0: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_start && !hw_mode) |=> (active_grp == '0)); // R2

    AST_ABORT_FREES: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_en && (wr_grp == active_grp)) |=> !busy); // R4

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !conv_done) |=> !done_flags[$past(rd_grp)]); // R5

    AST_IRQ_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (done_flags != '0)); // R6

    AST_DMA_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req |-> $past(dma_en)); // R6

    AST_CAL_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        cal_fail_set |=> sticky_flags[0]); // R10

endmodule

bind adc_grp_ctrl adc_grp_ctrl_chk #(.NUM_GRP(NUM_GRP), .GW(GW)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .hw_mode      (hw_mode),
    .dma_en       (dma_en),
    .wr_en        (wr_en),
    .wr_grp       (wr_grp),
    .rd_en        (rd_en),
    .rd_grp       (rd_grp),
    .conv_start   (conv_start),
    .conv_done    (conv_done),
    .busy         (busy),
    .active_grp   (active_grp),
    .done_flags   (done_flags),
    .irq          (irq),
    .dma_req      (dma_req),
    .cal_fail_set (cal_fail_set),
    .sticky_flags (sticky_flags)
);

// File: tb/adc_grp_ctrl_tb_top.sv
module adc_grp_ctrl_tb_top;

    localparam int NG = 4;
    localparam int CW = 5;
    localparam int RW = 12;
    localparam int GW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          hw_mode = 1'b0, cont_en = 1'b0, ovwr_en = 1'b0, dma_en = 1'b0;
    logic          wr_en = 1'b0;
    logic [GW-1:0] wr_grp = '0;
    logic [CW-1:0] wr_chan = '0;
    logic          wr_ie = 1'b0;
    logic          rd_en = 1'b0;
    logic [GW-1:0] rd_grp = '0;
    logic [RW-1:0] rd_data;
    logic [NG-1:0] hw_trig = '0;
    logic          conv_start;
    logic [CW-1:0] conv_chan;
    logic          conv_done = 1'b0;
    logic [RW-1:0] conv_result = '0;
    logic          busy;
    logic [GW-1:0] active_grp;
    logic [NG-1:0] done_flags;
    logic          irq, dma_req;
    logic          cal_fail_set = 1'b0, wake_set = 1'b0;
    logic [1:0]    sticky_clr = '0;
    logic [1:0]    sticky_flags;

    int n_chk = 0;
    int n_err = 0;

    always #10 clk = ~clk;

    adc_grp_ctrl #(.NUM_GRP(NG), .CH_W(CW), .RES_W(RW)) dut_i (
        .clk(clk), .rst_n(rst_n), .hw_mode(hw_mode), .cont_en(cont_en),
        .ovwr_en(ovwr_en), .dma_en(dma_en), .wr_en(wr_en), .wr_grp(wr_grp),
        .wr_chan(wr_chan), .wr_ie(wr_ie), .rd_en(rd_en), .rd_grp(rd_grp),
        .rd_data(rd_data), .hw_trig(hw_trig), .conv_start(conv_start),
        .conv_chan(conv_chan), .conv_done(conv_done), .conv_result(conv_result),
        .busy(busy), .active_grp(active_grp), .done_flags(done_flags),
        .irq(irq), .dma_req(dma_req), .cal_fail_set(cal_fail_set),
        .wake_set(wake_set), .sticky_clr(sticky_clr), .sticky_flags(sticky_flags)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic wr(int g, int ch, bit ie);
        wr_en = 1'b1; wr_grp = GW'(g); wr_chan = CW'(ch); wr_ie = ie;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic exp_start(int ch, string tag);
        #1;
        chk({tag, " start pulse"}, 32'(conv_start), 1);
        chk({tag, " channel"}, 32'(conv_chan), 32'(ch));
        tick();
    endtask

    task automatic finish(int r);
        conv_done = 1'b1; conv_result = RW'(r);
        tick();
        conv_done = 1'b0;
    endtask

    task automatic rd(int g);
        rd_en = 1'b1; rd_grp = GW'(g);
        tick();
        rd_en = 1'b0;
    endtask

    task automatic trig(int m);
        hw_trig = NG'(m);
        tick();
        hw_trig = '0;
    endtask

    task automatic quiet(string tag, int n);
        for (int k = 0; k < n; k++) begin
            #1;
            chk({tag, " no launch"}, 32'(conv_start), 0);
            chk({tag, " idle"}, 32'(busy), 0);
            tick();
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (3) tick();
        #1;
        chk("R11 busy", 32'(busy), 0);
        chk("R11 flags", 32'(done_flags), 0);
        chk("R11 irq", 32'(irq), 0);
        chk("R11 dma", 32'(dma_req), 0);
        chk("R11 start", 32'(conv_start), 0);
        chk("R11 sticky", 32'(sticky_flags), 0);
        rst_n = 1'b1;
        tick();

        // R1/R2/R5/R6: every channel through group 0 in software mode
        for (int c = 0; c < 32; c++) begin
            int r;
            bit ie;
            r  = (c * 97 + 5) % 4096;
            ie = (c % 2 == 0);
            dma_en = (c < 16);
            wr(0, c, ie);
            exp_start(c, "R1 R2 sweep");
            finish(r);
            #1;
            rd_grp = '0;
            #1;
            chk("R5 flag set", 32'(done_flags), 1);
            chk("R5 result", 32'(rd_data), 32'(r));
            chk("R6 irq", 32'(irq), 32'(ie));
            chk("R6 dma", 32'(dma_req), (c < 16) ? 1 : 0);
            rd(0);
            #1;
            chk("R5 read clear", 32'(done_flags), 0);
            chk("R6 irq single", 32'(irq), 0);
            tick();
        end
        dma_en = 1'b0;

        // R2: other groups and hardware lines cannot launch in software mode
        for (int g = 1; g < NG; g++) wr(g, 8 + g, 1'b1);
        trig(15);
        quiet("R2", 3);

        // R3: every trigger combination, served lowest index first
        hw_mode = 1'b1;
        tick();
        wr(0, 8, 1'b1);
        quiet("R3 write", 2);
        for (int m = 1; m < 16; m++) begin
            trig(m);
            for (int g = 0; g < NG; g++) begin
                if (m[g]) begin
                    exp_start(8 + g, "R3 order");
                    finish(100 * g + m);
                end
            end
            #1;
            chk("R3 all served", 32'(done_flags), 32'(m));
            for (int g = 0; g < NG; g++) begin
                if (m[g]) begin
                    rd_grp = GW'(g);
                    #1;
                    chk("R5 per group", 32'(rd_data), 32'(100 * g + m));
                    rd(g);
                end
            end
            #1;
            chk("R5 cleared", 32'(done_flags), 0);
        end

        // R4: abort the active group; a coincident done is discarded
        hw_mode = 1'b0;
        tick();
        wr(0, 5, 1'b0);
        exp_start(5, "R4 first");
        wr_en = 1'b1; wr_grp = '0; wr_chan = 5'd9; wr_ie = 1'b0;
        conv_done = 1'b1; conv_result = 12'd777;
        tick();
        wr_en = 1'b0; conv_done = 1'b0;
        #1;
        chk("R4 aborted", 32'(busy), 0);
        chk("R4 done dropped", 32'(done_flags), 0);
        exp_start(9, "R4 restart");
        finish(55);
        rd_grp = '0;
        #1;
        chk("R4 new result", 32'(rd_data), 55);
        rd(0);

        // R4: writing an idle group leaves the active one alone
        hw_mode = 1'b1;
        tick();
        trig(2);
        exp_start(9, "R4 grp1");
        wr(2, 20, 1'b1);
        #1;
        chk("R4 still busy", 32'(busy), 1);
        chk("R4 owner", 32'(active_grp), 1);
        finish(321);
        rd_grp = 2'd1;
        #1;
        chk("R4 flags", 32'(done_flags), 2);
        chk("R4 result kept", 32'(rd_data), 321);
        rd(1);

        // R7: repeated triggers while busy give one relaunch
        trig(4);
        exp_start(20, "R7 first");
        trig(4);
        trig(4);
        finish(1);
        exp_start(20, "R7 relaunch");
        finish(2);
        quiet("R7", 3);
        rd(2);

        // R8: drop versus replace of a flagged result
        trig(8);
        exp_start(11, "R8 a");
        finish(40);
        trig(8);
        exp_start(11, "R8 b");
        finish(41);
        rd_grp = 2'd3;
        #1;
        chk("R8 kept old", 32'(rd_data), 40);
        chk("R8 no irq on drop", 32'(irq), 0);
        ovwr_en = 1'b1;
        trig(8);
        exp_start(11, "R8 c");
        finish(42);
        #1;
        chk("R8 replaced", 32'(rd_data), 42);
        chk("R8 irq on replace", 32'(irq), 1);
        ovwr_en = 1'b0;
        rd(3);

        // R9: continuous relaunch, then stop
        hw_mode = 1'b0;
        cont_en = 1'b1;
        tick();
        wr(0, 3, 1'b0);
        exp_start(3, "R9 first");
        finish(10);
        exp_start(3, "R9 second");
        finish(11);
        exp_start(3, "R9 third");
        cont_en = 1'b0;
        finish(12);
        quiet("R9 stop", 3);
        rd(0);

        // R10: sticky flags
        cal_fail_set = 1'b1; wake_set = 1'b1;
        tick();
        cal_fail_set = 1'b0; wake_set = 1'b0;
        #1;
        chk("R10 both set", 32'(sticky_flags), 3);
        sticky_clr = 2'b01;
        tick();
        #1;
        chk("R10 clear cal", 32'(sticky_flags), 2);
        sticky_clr = 2'b11; cal_fail_set = 1'b1;
        tick();
        sticky_clr = 2'b00; cal_fail_set = 1'b0;
        #1;
        chk("R10 set wins", 32'(sticky_flags), 1);
        sticky_clr = 2'b01;
        tick();
        sticky_clr = 2'b00;
        #1;
        chk("R10 all clear", 32'(sticky_flags), 0);

        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule